// File: doc/BRIEF.md
# Program Enable and Block-Lock Guard

This block decides whether a serial memory may begin a program operation, and it holds the protection setup that governs that decision. A command decoder sends it one-cycle strobes for "enable programming", "disable programming" and "program the status byte", plus a request pulse carrying the target byte address. The guard answers every request, one cycle later, with either a grant pulse or a reject pulse.

The guard keeps a program-enable latch and a 3-bit lock code. The lock code picks one of eight address ranges that refuse programming. Locked bytes can still be read, because the guard only governs writes. An active-low protect input vetoes all nonvolatile writes. If that input falls while chip select is active and a granted program has not started yet, the guard cancels the program and emits an abort pulse. Once the write cycle has begun, the protect input no longer affects it.

The lock code models nonvolatile storage. Reset does not clear it, and only an accepted status-program command changes it. The status byte is presented for readback as follows: bits 2:0 hold the lock code, bit 3 holds the enable latch, and bits 7:4 read zero.

Top module: `pgm_guard`

## Requirements
- R1: A program request (`pgmReq`) made while the enable latch is clear produces a `pgmReject` pulse in the next cycle and no `pgmGrant`.
- R2: `cmdEnable` sets the enable latch and `cmdDisable` clears it. When both arrive in the same cycle, the latch ends up clear. Status bit 3 shows the latch.
- R3: The enable latch is clear after reset. It also clears in the cycle after `pgmDone` ends a started program cycle.
- R4: While `wrProtectN` is low, every program request is rejected and a status-program command leaves the status byte unchanged.
- R5: Suppose a granted program is waiting for `pgmStart` and `wrProtectN` falls while `csN` is low. Then `pgmAbort` pulses for exactly one cycle in the next cycle, and the waiting program is dropped, so a new request can be granted. The same fall with `csN` high produces no abort.
- R6: If `pgmStart` coincides with the protect fall, or the fall comes after the start, there is no abort, and the cycle runs on to `pgmDone`.
- R7: The lock code selects which addresses refuse programming. With A the top three address bits, the ranges are:
  - 0: no address is locked.
  - 1: A=7 is locked.
  - 2: A>=6 is locked.
  - 3: A>=4 is locked.
  - 4: A<4 is locked.
  - 5: A<2 is locked.
  - 6: A=0 is locked.
  - 7: every address is locked.

  A request to a locked address is rejected.
- R8: A status-program command is accepted only when the latch is set, `wrProtectN` is high and no program is waiting or running. When accepted, it loads `lockIn` into status bits 2:0 and clears the latch. At all other times, the lock code holds its value.
- R9: Reset does not change the lock code.
- R10: A request made while a granted program is waiting or running is rejected.
- R11: After reset, `pgmGrant`, `pgmReject` and `pgmAbort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| csN | input | 1 | Chip select, active low |
| wrProtectN | input | 1 | Write protect pin; low blocks nonvolatile writes |
| cmdEnable | input | 1 | Decoded strobe: set the enable latch |
| cmdDisable | input | 1 | Decoded strobe: clear the enable latch |
| cmdStatusPgm | input | 1 | Decoded strobe: program the status byte |
| lockIn | input | 3 | Lock code carried by the status-program data byte |
| pgmReq | input | 1 | Program request pulse |
| pgmAddr | input | ADDR_W | Target byte address of the request |
| pgmStart | input | 1 | The nonvolatile write cycle has begun |
| pgmDone | input | 1 | The sector program cycle has completed |
| pgmGrant | output | 1 | Request accepted (one-cycle pulse) |
| pgmReject | output | 1 | Request refused (one-cycle pulse) |
| pgmAbort | output | 1 | Waiting program cancelled by the protect pin |
| statusOut | output | 8 | Status byte: lock code in 2:0, enable latch in 3 |

## Verification
Cancellation and the start of the write cycle can fall in the same cycle. The bench provokes this by driving `pgmStart` high and `wrProtectN` low on the same edge while a grant is waiting. It judges the outcome in two ways. First, `pgmAbort` must stay low. Second, the cycle must still be running: a fresh request is rejected as busy, and a later `pgmDone` clears the enable latch. The bench also covers the same fall with chip select inactive and the fall after the start, and sweeps all eight lock codes at the edges of their ranges.

// File: rtl/pgm_guard_pkg.sv
package pgm_guard_pkg;
  localparam int LOCK_W   = 3;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic loadLock;
  } guardStrobe_t;

  typedef enum logic [1:0] {
    G_IDLE = 2'd0,
    G_PEND = 2'd1,
    G_BUSY = 2'd2
  } guardState_t;
endpackage

// File: rtl/pgm_guard_dp.sv
module pgm_guard_dp
  import pgm_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  guardStrobe_t        strobe,
  input  logic [LOCK_W-1:0]   lockIn,
  input  logic [ADDR_W-1:0]   pgmAddr,
  output logic                enLatch,
  output logic                addrLocked,
  output logic [STATUS_W-1:0] statusOut
);
  localparam int TOP = ADDR_W - 1;

  // Lock code models nonvolatile storage: no reset term.
  logic [LOCK_W-1:0] lockField = '0;
  logic [2:0]        hi3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enLatch <= 1'b0;
    else if (strobe.clrEn)    enLatch <= 1'b0;
    else if (strobe.setEn)    enLatch <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.loadLock) lockField <= lockIn;
  end

  assign hi3 = pgmAddr[TOP -: 3];

  always_comb begin
    case (lockField)
      3'd0:    addrLocked = 1'b0;
      3'd1:    addrLocked = (hi3 == 3'b111);
      3'd2:    addrLocked = (hi3[2:1] == 2'b11);
      3'd3:    addrLocked = hi3[2];
      3'd4:    addrLocked = ~hi3[2];
      3'd5:    addrLocked = (hi3[2:1] == 2'b00);
      3'd6:    addrLocked = (hi3 == 3'b000);
      default: addrLocked = 1'b1;
    endcase
  end

  assign statusOut = {{(STATUS_W-LOCK_W-1){1'b0}}, enLatch, lockField};
endmodule

// File: rtl/pgm_guard_ctrl.sv
module pgm_guard_ctrl
  import pgm_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         wrProtectN,
  input  logic         cmdEnable,
  input  logic         cmdDisable,
  input  logic         cmdStatusPgm,
  input  logic         pgmReq,
  input  logic         pgmStart,
  input  logic         pgmDone,
  input  logic         enLatch,
  input  logic         addrLocked,
  output guardStrobe_t strobe,
  output logic         pgmGrant,
  output logic         pgmReject,
  output logic         pgmAbort
);
  guardState_t state;
  logic        protPrev;
  logic        protFall;
  logic        isIdle;
  logic        grantNow;
  logic        rejectNow;
  logic        abortNow;
  logic        doneNow;

  assign protFall  = protPrev & ~wrProtectN;
  assign isIdle    = (state == G_IDLE);
  assign grantNow  = pgmReq & isIdle & enLatch & wrProtectN & ~addrLocked;
  assign rejectNow = pgmReq & ~grantNow;
  assign abortNow  = (state == G_PEND) & protFall & ~csN & ~pgmStart;
  assign doneNow   = (state == G_BUSY) & pgmDone;

  always_comb begin
    strobe.loadLock = cmdStatusPgm & isIdle & enLatch & wrProtectN & ~pgmReq;
    strobe.setEn    = cmdEnable;
    strobe.clrEn    = cmdDisable | doneNow | strobe.loadLock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= G_IDLE;
      protPrev  <= 1'b0;
      pgmGrant  <= 1'b0;
      pgmReject <= 1'b0;
      pgmAbort  <= 1'b0;
    end else begin
      protPrev  <= wrProtectN;
      pgmGrant  <= grantNow;
      pgmReject <= rejectNow;
      pgmAbort  <= abortNow;
      case (state)
        G_IDLE: if (grantNow) state <= G_PEND;
        G_PEND: begin
          if (pgmStart)      state <= G_BUSY;
          else if (abortNow) state <= G_IDLE;
        end
        G_BUSY: if (pgmDone) state <= G_IDLE;
        default: state <= G_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgm_guard.sv
module pgm_guard
  import pgm_guard_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                wrProtectN,
  input  logic                cmdEnable,
  input  logic                cmdDisable,
  input  logic                cmdStatusPgm,
  input  logic [LOCK_W-1:0]   lockIn,
  input  logic                pgmReq,
  input  logic [ADDR_W-1:0]   pgmAddr,
  input  logic                pgmStart,
  input  logic                pgmDone,
  output logic                pgmGrant,
  output logic                pgmReject,
  output logic                pgmAbort,
  output logic [STATUS_W-1:0] statusOut
);
  guardStrobe_t strobe;
  logic         enLatch;
  logic         addrLocked;

  pgm_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrProtectN(wrProtectN),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdStatusPgm(cmdStatusPgm),
    .pgmReq(pgmReq), .pgmStart(pgmStart), .pgmDone(pgmDone),
    .enLatch(enLatch), .addrLocked(addrLocked), .strobe(strobe),
    .pgmGrant(pgmGrant), .pgmReject(pgmReject), .pgmAbort(pgmAbort)
  );

  pgm_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lockIn(lockIn),
    .pgmAddr(pgmAddr), .enLatch(enLatch), .addrLocked(addrLocked),
    .statusOut(statusOut)
  );
endmodule

// File: rtl/pgm_guard_chk.sv
module pgm_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       wrProtectN,
  input logic       pgmReq,
  input logic       cmdStatusPgm,
  input logic       pgmGrant,
  input logic       pgmReject,
  input logic       pgmAbort,
  input logic [7:0] statusOut
);
  // R1
  latch_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq && !statusOut[3] |=> pgmReject && !pgmGrant);

  // R4
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq && !wrProtectN |=> !pgmGrant);

  // R5
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmAbort |-> !$past(wrProtectN) && !$past(csN));

  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmAbort |=> !pgmAbort);

  // R7
  full_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq && statusOut[2:0] == 3'd7 |=> !pgmGrant);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStatusPgm |=> $stable(statusOut[2:0]));

  // R1
  answer_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pgmGrant, pgmReject}));
endmodule

bind pgm_guard pgm_guard_chk chk (.*);

// File: tb/pgm_guard_test.sv
`timescale 1ns/1ps
module pgm_guard_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b0;
  logic       wrProtectN = 1'b1;
  logic       cmdEnable = 1'b0;
  logic       cmdDisable = 1'b0;
  logic       cmdStatusPgm = 1'b0;
  logic [2:0] lockIn = '0;
  logic       pgmReq = 1'b0;
  logic [9:0] pgmAddr = '0;
  logic       pgmStart = 1'b0;
  logic       pgmDone = 1'b0;
  logic       pgmGrant, pgmReject, pgmAbort;
  logic [7:0] statusOut;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  pgm_guard uut (.*);

  // {lock code, address, expect grant}
  localparam logic [13:0] VEC [15] = '{
    {3'd0, 10'h3FF, 1'b1},
    {3'd1, 10'h380, 1'b0}, {3'd1, 10'h37F, 1'b1},
    {3'd2, 10'h300, 1'b0}, {3'd2, 10'h2FF, 1'b1},
    {3'd3, 10'h200, 1'b0}, {3'd3, 10'h1FF, 1'b1},
    {3'd4, 10'h1FF, 1'b0}, {3'd4, 10'h200, 1'b1},
    {3'd5, 10'h0FF, 1'b0}, {3'd5, 10'h100, 1'b1},
    {3'd6, 10'h07F, 1'b0}, {3'd6, 10'h080, 1'b1},
    {3'd7, 10'h000, 1'b0}, {3'd7, 10'h3FF, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic doEnable();
    cmdEnable = 1'b1; cyc(); cmdEnable = 1'b0;
  endtask

  task automatic doStatus(input logic [2:0] code);
    cmdStatusPgm = 1'b1; lockIn = code; cyc(); cmdStatusPgm = 1'b0;
  endtask

  task automatic doReq(input logic [9:0] a);
    pgmReq = 1'b1; pgmAddr = a; cyc(); pgmReq = 1'b0;
  endtask

  task automatic startDone();
    pgmStart = 1'b1; cyc(); pgmStart = 1'b0;
    pgmDone = 1'b1; cyc(); pgmDone = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R11 / R3: reset state
    check("R11 grant", {7'd0, pgmGrant}, 8'd0);
    check("R11 reject", {7'd0, pgmReject}, 8'd0);
    check("R11 abort", {7'd0, pgmAbort}, 8'd0);
    rstN = 1'b1;
    cyc();
    check("R3 latch after reset", {7'd0, statusOut[3]}, 8'd0);

    // R1: request without latch
    doReq(10'h000);
    check("R1 reject", {6'd0, pgmGrant, pgmReject}, 8'b01);

    // R7 / R8: lock table walk
    foreach (VEC[i]) begin
      logic [2:0] code;
      logic [9:0] a;
      logic       exp;
      {code, a, exp} = VEC[i];
      doEnable();
      doStatus(code);
      check("R8 status load", statusOut, {5'd0, code});
      doEnable();
      doReq(a);
      check("R7 answer", {6'd0, pgmGrant, pgmReject}, {6'd0, exp, ~exp});
      if (exp) begin
        startDone();
        check("R3 latch clear on done", {7'd0, statusOut[3]}, 8'd0);
      end
    end

    // R9: reset keeps lock code (currently 7)
    rstN = 1'b0; cyc(); rstN = 1'b1; cyc();
    check("R9 lock kept", statusOut, 8'h07);

    // R8: status program without latch ignored
    doStatus(3'd0);
    check("R8 ignored no latch", statusOut, 8'h07);
    doEnable(); doStatus(3'd0);
    check("R8 unlock", statusOut, 8'h00);

    // R2: enable/disable
    doEnable();
    check("R2 set", {7'd0, statusOut[3]}, 8'd1);
    cmdDisable = 1'b1; cyc(); cmdDisable = 1'b0;
    check("R2 clear", {7'd0, statusOut[3]}, 8'd0);
    doEnable();
    cmdEnable = 1'b1; cmdDisable = 1'b1; cyc(); cmdEnable = 1'b0; cmdDisable = 1'b0;
    check("R2 disable wins", {7'd0, statusOut[3]}, 8'd0);

    // R4: protect low
    doEnable();
    wrProtectN = 1'b0; cyc();
    doReq(10'h000);
    check("R4 reject", {6'd0, pgmGrant, pgmReject}, 8'b01);
    doStatus(3'd5);
    check("R4 status unchanged", statusOut, 8'h08);
    wrProtectN = 1'b1; cyc();

    // R5: abort while pending
    doReq(10'h000);
    check("R5 grant", {6'd0, pgmGrant, pgmReject}, 8'b10);
    wrProtectN = 1'b0; cyc();
    check("R5 abort pulse", {7'd0, pgmAbort}, 8'd1);
    cyc();
    check("R5 abort one cycle", {7'd0, pgmAbort}, 8'd0);
    wrProtectN = 1'b1; cyc();
    doReq(10'h000);
    check("R5 regrant after abort", {6'd0, pgmGrant, pgmReject}, 8'b10);

    // R5: fall with csN high -> no abort
    csN = 1'b1; wrProtectN = 1'b0; cyc();
    check("R5 no abort csN high", {7'd0, pgmAbort}, 8'd0);
    wrProtectN = 1'b1; csN = 1'b0; cyc();
    startDone();
    check("R3 done clears", {7'd0, statusOut[3]}, 8'd0);

    // R6 / R10: start coincides with fall
    doEnable();
    doReq(10'h000);
    check("R6 grant", {6'd0, pgmGrant, pgmReject}, 8'b10);
    pgmStart = 1'b1; wrProtectN = 1'b0; cyc(); pgmStart = 1'b0;
    check("R6 no abort", {7'd0, pgmAbort}, 8'd0);
    wrProtectN = 1'b1; cyc();
    doEnable();
    doReq(10'h000);
    check("R10 busy reject", {6'd0, pgmGrant, pgmReject}, 8'b01);
    pgmDone = 1'b1; cyc(); pgmDone = 1'b0;
    check("R6 cycle completed", {7'd0, statusOut[3]}, 8'd0);

    // R10: request while pending
    doEnable();
    doReq(10'h000);
    doReq(10'h000);
    check("R10 pending reject", {6'd0, pgmGrant, pgmReject}, 8'b01);
    startDone();

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule